// File: doc/BRIEF.md
# Processor Status Byte Register with User Flags

This block keeps the two status bytes of a small 8-bit processor: an upper byte holding control bits and a lower byte whose top two bits form the condition code. The processor core can set bits, clear bits and test bits in either byte with a mask. It can also copy either byte straight from the data bus into the register, and read either byte out onto the bus. A lower-byte load therefore restores the saved condition code in one step, and no general register is involved.

A mode input selects between two behaviours. In legacy mode, two bits of the upper byte are reserved: they always read as zero and they ignore writes. In extended mode, those same two bits become user flags. Software can set, clear and test them like any other bit. Addressing the memory for the load and store traffic is left to the surrounding core. The block only accepts and presents bytes.

Top module: `psw_flag_reg`

## Requirements
- R1: After a synchronous active-low reset, both status bytes and the condition code are zero.
- R2: In extended mode (`ext_mode`=1), the upper-byte bits with mask 0x10 (user flag 1) and 0x08 (user flag 2) can be set, cleared, loaded and tested like the other bits.
- R3: In legacy mode (`ext_mode`=0), upper-byte bits 0x18 always read as zero on `status_hi` and `dout`. A set or load leaves them zero, and a test whose mask includes them yields condition code 10.
- R4: Op code 01 (set) ORs `mask` into the byte chosen by `op_sel` (0 = lower, 1 = upper) on the next clock edge.
- R5: Op code 10 (clear) ANDs the chosen byte with the inverse of `mask` on the next clock edge.
- R6: Op code 11 (test) writes condition code 00 into lower bits [7:6] when every masked bit of the chosen byte is one, and 10 otherwise. Op code 00 does nothing. `cc` always shows lower bits [7:6].
- R7: When `ld_en` is 1, the byte chosen by `ld_sel` (0 = lower, 1 = upper) takes the value of `din` on the next clock edge.
- R8: `dout` shows the visible lower byte when `st_sel`=0 and the visible upper byte when `st_sel`=1, with no clock delay.
- R9: A load has priority over a set, clear or test-result write to the same byte in the same cycle. This includes the condition code bits of the lower byte.
- R10: A lower-byte load restores `cc` from `din[7:6]` and leaves the upper byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_mode | input | 1 | 1 = user flags enabled, 0 = legacy reserved bits |
| op | input | 2 | Masked operation: 00 none, 01 set, 10 clear, 11 test |
| op_sel | input | 1 | Target byte of `op`: 0 lower, 1 upper |
| mask | input | 8 | Bit mask for `op` |
| ld_en | input | 1 | Load a byte from `din` |
| ld_sel | input | 1 | Target byte of the load: 0 lower, 1 upper |
| din | input | 8 | Data bus byte to load |
| st_sel | input | 1 | Byte shown on `dout`: 0 lower, 1 upper |
| dout | output | 8 | Stored byte presented to the data bus |
| status_hi | output | 8 | Visible upper status byte |
| status_lo | output | 8 | Lower status byte |
| cc | output | 2 | Condition code, lower bits [7:6] |

## Verification
The hardest case to reach is a collision: a load and a masked operation land on the same byte in the same cycle, and the test result would otherwise write the condition code that the lower load also writes. Directed steps issue a test together with a lower load, and a set together with an upper load. They then check that the loaded byte wins outright. The mode change that makes stored user flags disappear is also hard to hit. To reach it, the bench sets both flags in extended mode, switches to legacy mode, and later returns to extended mode to confirm the flags were cleared. A full sweep over every mask value, in both modes and for both bytes, covers the masked operations.

// File: rtl/psw_pkg.sv
// Package: shared types and constants for the status byte register.
// Assumes an 8-bit data path and a 2-bit condition code at the top of the lower byte.
package psw_pkg;
    localparam int BYTE_W = 8;
    localparam int CC_W   = 2;
    localparam int CC_LSB = BYTE_W - CC_W;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_TEST = 2'b11
    } psw_op_e;

    localparam logic [CC_W-1:0] CC_EQ = 2'b00;
    localparam logic [CC_W-1:0] CC_NE = 2'b10;
endpackage

// File: rtl/psw_byte_next.sv
// Module: next-value logic for one status byte.
// Applies a masked set or clear when this byte is the target, lets a load
// override it, and then drops the bits listed in drop_mask (reserved bits).
// Assumes cur is the visible (already masked) value of the byte.
module psw_byte_next
    import psw_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] cur,
    input  logic [1:0]   op,
    input  logic         hit,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] drop_mask,
    output logic [W-1:0] nxt
);
    logic [W-1:0] masked_val;

    // Purpose: masked set or clear of the current value.
    always_comb begin
        masked_val = cur;
        if (hit) begin
            case (psw_op_e'(op))
                OP_SET:  masked_val = cur | mask;
                OP_CLR:  masked_val = cur & ~mask;
                default: masked_val = cur;
            endcase
        end
    end

    // Purpose: a load overrides the masked result; reserved bits are dropped.
    always_comb begin
        nxt = (ld ? din : masked_val) & ~drop_mask;
    end
endmodule

// File: rtl/psw_test_unit.sv
// Module: evaluates the masked test.
// Reports "equal" when all masked bits of the chosen byte are one.
// Assumes sel_byte is the visible value seen by software.
module psw_test_unit
    import psw_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0]    sel_byte,
    input  logic [W-1:0]    mask,
    output logic [CC_W-1:0] cc_res
);
    // Purpose: compare the masked bits against the mask itself.
    always_comb begin
        cc_res = ((sel_byte & mask) == mask) ? CC_EQ : CC_NE;
    end
endmodule

// File: rtl/psw_flag_reg.sv
// Module: upper and lower processor status bytes with masked set, clear and
// test, direct byte load and store, and a mode that makes two upper bits
// either reserved (read as zero) or user flags.
// Assumes op, mask and load controls are valid for one cycle each, and that
// the condition code lives in the top CC_W bits of the lower byte.
module psw_flag_reg
    import psw_pkg::*;
#(
    parameter int             W       = BYTE_W,
    parameter logic [W-1:0]   UF_MASK = 8'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_mode,
    input  logic [1:0]      op,
    input  logic            op_sel,
    input  logic [W-1:0]    mask,
    input  logic            ld_en,
    input  logic            ld_sel,
    input  logic [W-1:0]    din,
    input  logic            st_sel,
    output logic [W-1:0]    dout,
    output logic [W-1:0]    status_hi,
    output logic [W-1:0]    status_lo,
    output logic [CC_W-1:0] cc
);
    localparam int NBYTES = 2;
    localparam int LO     = 0;
    localparam int HI     = 1;
    localparam int CC_POS = W - CC_W;

    logic [W-1:0]    byte_q   [NBYTES];
    logic [W-1:0]    byte_nx  [NBYTES];
    logic [W-1:0]    vis      [NBYTES];
    logic [W-1:0]    lo_final;
    logic [CC_W-1:0] cc_res;
    logic            test_fire;
    logic            ld_lo;

    // One update unit per byte; only the upper byte carries reserved bits.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        localparam logic [W-1:0] RSV = (g == HI) ? UF_MASK : '0;
        logic [W-1:0] drop;

        // Purpose: the reserved bits are hidden from readers in legacy mode.
        assign vis[g] = ext_mode ? byte_q[g] : (byte_q[g] & ~RSV);
        // Purpose: the reserved bits are dropped from writes in legacy mode.
        assign drop   = ext_mode ? '0 : RSV;

        psw_byte_next #(.W(W)) u_next (
            .cur       (vis[g]),
            .op        (op),
            .hit       (op_sel == 1'(g)),
            .ld        (ld_en && (ld_sel == 1'(g))),
            .din       (din),
            .mask      (mask),
            .drop_mask (drop),
            .nxt       (byte_nx[g])
        );
    end

    psw_test_unit #(.W(W)) u_test (
        .sel_byte (vis[op_sel]),
        .mask     (mask),
        .cc_res   (cc_res)
    );

    assign test_fire = (psw_op_e'(op) == OP_TEST);
    assign ld_lo     = ld_en && (ld_sel == 1'b0);

    // Purpose: the test result writes the lower byte's condition code unless a lower load wins.
    always_comb begin
        lo_final = byte_nx[LO];
        if (test_fire && !ld_lo) begin
            lo_final[CC_POS +: CC_W] = cc_res;
        end
    end

    // Purpose: the status byte registers with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q[LO] <= '0;
            byte_q[HI] <= '0;
        end else begin
            byte_q[LO] <= lo_final;
            byte_q[HI] <= byte_nx[HI];
        end
    end

    assign status_lo = vis[LO];
    assign status_hi = vis[HI];
    assign cc        = vis[LO][CC_POS +: CC_W];
    assign dout      = st_sel ? vis[HI] : vis[LO];

    // R3: after a legacy-mode cycle, the stored reserved bits are zero.
    a_r3_legacy_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ext_mode)) |-> ((byte_q[HI] & UF_MASK) == '0));

    // R9: a lower load wins over any masked op or test on that byte.
    a_r9_load_wins_lower: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ld_en && !ld_sel) |-> (status_lo == $past(din)));

    // R4: the set leaves all masked bits of the lower byte at one.
    a_r4_set_lower: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op == 2'b01 && !op_sel && !(ld_en && !ld_sel))
        |-> ((status_lo & $past(mask)) == $past(mask)));

    // R5: the clear leaves all masked bits of the lower byte at zero.
    a_r5_clear_lower: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op == 2'b10 && !op_sel && !(ld_en && !ld_sel))
        |-> ((status_lo & $past(mask)) == '0));

    // R6: the test result appears on cc one cycle later.
    a_r6_test_cc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op == 2'b11 && !(ld_en && !ld_sel))
        |-> (cc == ((($past(dout_sel_view) & $past(mask)) == $past(mask)) ? CC_EQ : CC_NE)));

    // R10: a lower load alone leaves the upper byte unchanged.
    a_r10_lower_load_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && ld_en && !ld_sel && !(op_sel && (op == 2'b01 || op == 2'b10)))
         && $stable(ext_mode)) |-> (status_hi == $past(status_hi)));

    logic [W-1:0] dout_sel_view;
    assign dout_sel_view = op_sel ? status_hi : status_lo;
endmodule

// File: tb/psw_flag_reg_tb.sv
module psw_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [1:0] op = 2'b00;
    logic       op_sel = 1'b0;
    logic [7:0] mask = 8'h00;
    logic       ld_en = 1'b0;
    logic       ld_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic       st_sel = 1'b0;
    logic [7:0] dout, status_hi, status_lo;
    logic [1:0] cc;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_lo = 8'h00;
    logic [7:0] m_hi = 8'h00;

    always #5 clk = ~clk;

    psw_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .op(op), .op_sel(op_sel),
        .mask(mask), .ld_en(ld_en), .ld_sel(ld_sel), .din(din), .st_sel(st_sel),
        .dout(dout), .status_hi(status_hi), .status_lo(status_lo), .cc(cc)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clocked step: drive at negedge, update the model, compare after the edge.
    task automatic step(input string tag, input logic e, input logic [1:0] o, input logic s,
                        input logic [7:0] mk, input logic l, input logic ls,
                        input logic [7:0] d, input logic ss);
        logic [7:0] nh, nl, cur;
        logic [1:0] tcc;
        @(negedge clk);
        ext_mode = e; op = o; op_sel = s; mask = mk; ld_en = l; ld_sel = ls; din = d; st_sel = ss;
        nh = e ? m_hi : (m_hi & ~8'h18);
        nl = m_lo;
        cur = s ? nh : nl;
        if (o == 2'b01) begin if (s) nh = nh | mk; else nl = nl | mk; end
        if (o == 2'b10) begin if (s) nh = nh & ~mk; else nl = nl & ~mk; end
        if (o == 2'b11) begin
            tcc = ((cur & mk) == mk) ? 2'b00 : 2'b10;
            nl[7:6] = tcc;
        end
        if (l) begin if (ls) nh = d; else nl = d; end
        if (!e) nh = nh & ~8'h18;
        m_hi = nh;
        m_lo = nl;
        @(posedge clk);
        #1;
        check8({tag, " lo"}, status_lo, m_lo);
        check8({tag, " hi"}, status_hi, m_hi);
        check8({tag, " cc"}, {6'b0, cc}, {6'b0, m_lo[7:6]});
        check8("R8 dout", dout, ss ? m_hi : m_lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check8("R1 lo", status_lo, 8'h00);
        check8("R1 hi", status_hi, 8'h00);
        check8("R1 cc", {6'b0, cc}, 8'h00);

        // Sweep: every mask, both modes, both bytes; R4 set, R5 clear, R6 test, R7 load
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 256; m++) begin
                    logic [7:0] pat;
                    pat = 8'(m * 37 + e * 11 + s) ^ 8'h5A;
                    step(e ? "R7 load" : "R3 load", e[0], 2'b00, 1'b0, 8'h00, 1'b1, s[0], pat, m[0]);
                    step(e ? "R4 set" : "R3 set", e[0], 2'b01, s[0], 8'(m), 1'b0, 1'b0, 8'h00, m[1]);
                    step("R5 clear", e[0], 2'b10, s[0], 8'(m) ^ 8'hF0, 1'b0, 1'b0, 8'h00, m[2]);
                    step("R6 test", e[0], 2'b11, s[0], 8'(m), 1'b0, 1'b0, 8'h00, m[3]);
                end
            end
        end

        // R2: user flags in extended mode
        step("R2 clr", 1'b1, 2'b10, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b1);
        step("R2 set", 1'b1, 2'b01, 1'b1, 8'h18, 1'b0, 1'b0, 8'h00, 1'b1);
        check8("R2 flags set", status_hi, 8'h18);
        step("R2 test", 1'b1, 2'b11, 1'b1, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1);
        check8("R2 test eq", {6'b0, cc}, 8'h00);
        // R3: switch to legacy: flags vanish, test on them fails, set ignored
        step("R3 switch", 1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check8("R3 hidden", status_hi & 8'h18, 8'h00);
        step("R3 set", 1'b0, 2'b01, 1'b1, 8'h18, 1'b0, 1'b0, 8'h00, 1'b1);
        step("R3 test", 1'b0, 2'b11, 1'b1, 8'h08, 1'b0, 1'b0, 8'h00, 1'b1);
        check8("R3 test ne", {6'b0, cc}, 8'h02);
        step("R3 back", 1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        check8("R3 cleared", status_hi & 8'h18, 8'h00);

        // R9: load vs set on upper, load vs test on lower
        step("R9 set+ld hi", 1'b1, 2'b01, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h24, 1'b1);
        check8("R9 hi", status_hi, 8'h24);
        step("R9 test+ld lo", 1'b1, 2'b11, 1'b0, 8'h00, 1'b1, 1'b0, 8'h81, 1'b0);
        check8("R9 cc", {6'b0, cc}, 8'h02);
        // R10: lower load restores cc, upper untouched
        step("R10 ld lo", 1'b1, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h43, 1'b0);
        check8("R10 cc", {6'b0, cc}, 8'h01);
        check8("R10 hi", status_hi, 8'h24);

        // R1: reset in the middle of a run
        @(negedge clk) rst_n = 1'b0; ld_en = 1'b0; op = 2'b00;
        @(posedge clk); #1;
        m_lo = 8'h00; m_hi = 8'h00;
        check8("R1 mid lo", status_lo, 8'h00);
        check8("R1 mid hi", status_hi, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule